// File: doc/BRIEF.md
# Three-Channel Timer Bus Register Interface

This block sits between an 8-bit processor bus and three 16-bit counting channels. A 2-bit address picks one of the three count ports (0, 1, 2) or the control port (3). Through the control port software configures a channel, freezes a copy of a channel's count, or uses a single command to freeze counts and status for several channels at once. Through the count ports it loads new 16-bit counts one byte at a time and reads counts back one byte at a time.

The block keeps the per-channel byte sequencing, the frozen count copies and the frozen status bytes. It hands each channel a one-cycle load pulse with the assembled count, a one-cycle configuration pulse, and the current operating mode and number format. In return it takes each channel's live count, its output level and a transfer pulse that tells when a loaded count has entered the counting element. The counting itself is done elsewhere. Bus reads return data combinationally for the selected address. A read strobe or a write strobe takes effect at the clock edge where it is high.

Top module: `tmr_busif`

## Requirements
- R1: After reset every channel is in low-byte-only access, mode 0, binary format, with no frozen count, no frozen status and the pending-count flag clear, and no load or configuration pulse is issued.
- R2: A write to port 3 with bits 7:6 equal to 0, 1 or 2 and bits 5:4 non-zero configures that channel: bits 5:4 are the access kind (1 low byte only, 2 high byte only, 3 low then high), bits 3:1 the mode and bit 0 the BCD flag. The mode and flag appear on `ch_mode`/`ch_bcd` together with a one-cycle `ch_cfg` pulse in the cycle after the write.
- R3: In low-byte-only access a count-port write loads {8'h00, byte}, and in high-byte-only access it loads {byte, 8'h00}. `ch_load` pulses for one cycle, the cycle after the write, with the value on `ch_load_val`, and at most one channel is loaded per cycle.
- R4: In low-then-high access the first write is held and produces no load, and the second write loads {second, first}.
- R5: A port-3 write with bits 5:4 equal to 0 freezes the addressed channel's live count. Reads then return the frozen value (low byte, high byte, or low then high, following the access kind), after which the freeze is released and reads return the live count again.
- R6: A count freeze request for a channel whose frozen count has not been fully read is ignored, and the older frozen value is kept.
- R7: A port-3 write with bits 7:6 equal to 3 is a multi-channel command: bit 1, 2 and 3 select channels 0, 1 and 2, bit 5 low freezes the count and bit 4 low freezes the status of every selected channel, and unselected channels are untouched.
- R8: A frozen status byte is {output level, pending-count flag, access kind[1:0], mode[2:0], BCD}, from bit 7 down to bit 0. A status freeze request is ignored while an earlier frozen status is unread.
- R9: A frozen status is returned before any frozen count, and reading it releases it.
- R10: Without a freeze, reads return the live count: its low byte in low-byte-only access, its high byte in high-byte-only access, and alternately low then high byte in low-then-high access.
- R11: A configuration write for a channel restarts both its read and its write byte order at the low byte.
- R12: The pending-count flag is set by every count load and cleared by a transfer pulse from the channel. A load wins over a transfer in the same cycle.
- R13: A read of port 3 returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read is consumed at the clock edge |
| bus_addr | input | 2 | 0..2 count ports, 3 control port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ch_load | output | NCH | One-cycle count load pulse per channel |
| ch_load_val | output | NCH*16 | Assembled count per channel |
| ch_cfg | output | NCH | One-cycle configuration pulse per channel |
| ch_mode | output | NCH*3 | Operating mode per channel |
| ch_bcd | output | NCH | BCD number format per channel |
| ch_live | input | NCH*16 | Live count per channel |
| ch_out | input | NCH | Output level per channel |
| ch_xfer | input | NCH | Loaded count has entered the counting element |

## Verification
The assertions assume that the bus never raises `bus_wr` and `bus_rd` in the same cycle. Under that assumption a load pulse can only follow a count-port write and a configuration pulse can only follow a control write. The bench drives the bus through tasks that raise exactly one strobe per operation and then leave the bus idle for a cycle, in both the directed and the random phase. Its counter model produces transfer pulses only as a response to load pulses, which is the ordering the pending-count flag relies on.

// File: rtl/tmr_busif_pkg.sv
package tmr_busif_pkg;

   localparam int CNT_W  = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ACC_FREEZE = 2'd0,
      ACC_LO     = 2'd1,
      ACC_HI     = 2'd2,
      ACC_WORD   = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      FRZ_NONE = 2'd0,
      FRZ_LO   = 2'd1,
      FRZ_HI   = 2'd2,
      FRZ_WORD = 2'd3
   } frz_e;

   typedef struct packed {
      logic       cfg;
      logic       cnt_frz;
      logic       st_frz;
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } chan_cmd_t;

   function automatic frz_e frz_of(acc_e a);
      case (a)
         ACC_HI:   return FRZ_HI;
         ACC_WORD: return FRZ_WORD;
         default:  return FRZ_LO;
      endcase
   endfunction

endpackage

// File: rtl/tmr_busif_decode.sv
module tmr_busif_decode
   import tmr_busif_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [1:0]            bus_addr,
   input  logic [BYTE_W-1:0]     bus_wdata,
   output chan_cmd_t [NCH-1:0]   cmd,
   output logic [NCH-1:0]        cnt_wr,
   output logic [NCH-1:0]        cnt_rd
);

   localparam logic [1:0] CTRL_PORT = 2'd3;

   logic       ctl_wr;
   logic       multi;
   logic [1:0] sel;
   acc_e       acc;

   assign ctl_wr = bus_wr && (bus_addr == CTRL_PORT);
   assign sel    = bus_wdata[7:6];
   assign multi  = (sel == 2'd3);
   assign acc    = acc_e'(bus_wdata[5:4]);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      logic pick;
      assign hit  = ctl_wr && !multi && (sel == 2'(c));
      assign pick = ctl_wr && multi && bus_wdata[c+1];

      assign cmd[c].cfg     = hit && (acc != ACC_FREEZE);
      assign cmd[c].cnt_frz = (hit && (acc == ACC_FREEZE)) || (pick && !bus_wdata[5]);
      assign cmd[c].st_frz  = pick && !bus_wdata[4];
      assign cmd[c].acc     = acc;
      assign cmd[c].mode    = bus_wdata[3:1];
      assign cmd[c].bcd     = bus_wdata[0];

      assign cnt_wr[c] = bus_wr && (bus_addr == 2'(c));
      assign cnt_rd[c] = bus_rd && (bus_addr == 2'(c));
   end

endmodule

// File: rtl/tmr_busif_chan.sv
module tmr_busif_chan
   import tmr_busif_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  chan_cmd_t         cmd,
   input  logic              cnt_wr,
   input  logic              cnt_rd,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  live,
   input  logic              out_lvl,
   input  logic              xfer,
   output logic [BYTE_W-1:0] rbyte,
   output logic              load,
   output logic [CNT_W-1:0]  load_val,
   output logic              cfg,
   output logic [2:0]        mode,
   output logic              bcd
);

   acc_e              acc_q;
   logic [2:0]        mode_q;
   logic              bcd_q;
   logic              wr_hi_q;
   logic              rd_hi_q;
   logic [BYTE_W-1:0] wlo_q;
   frz_e              frz_q;
   logic [CNT_W-1:0]  frz_val_q;
   logic              st_v_q;
   logic [BYTE_W-1:0] st_q;
   logic              pend_q;
   logic              load_q;
   logic [CNT_W-1:0]  load_val_q;
   logic              cfg_q;

   logic              do_load;
   logic [CNT_W-1:0]  nxt_val;

   // assemble the count from the bytes written so far
   always_comb begin
      do_load = 1'b0;
      nxt_val = '0;
      if (cnt_wr) begin
         case (acc_q)
            ACC_HI: begin
               do_load = 1'b1;
               nxt_val = {wdata, 8'h00};
            end
            ACC_WORD: begin
               do_load = wr_hi_q;
               nxt_val = {wdata, wlo_q};
            end
            default: begin
               do_load = 1'b1;
               nxt_val = {8'h00, wdata};
            end
         endcase
      end
   end

   // byte offered to the bus: status, then frozen count, then live count
   always_comb begin
      if (st_v_q) begin
         rbyte = st_q;
      end else begin
         case (frz_q)
            FRZ_LO, FRZ_WORD: rbyte = frz_val_q[7:0];
            FRZ_HI:           rbyte = frz_val_q[15:8];
            default: begin
               if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_hi_q))
                  rbyte = live[15:8];
               else
                  rbyte = live[7:0];
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= ACC_LO;
         mode_q     <= '0;
         bcd_q      <= 1'b0;
         wr_hi_q    <= 1'b0;
         rd_hi_q    <= 1'b0;
         wlo_q      <= '0;
         frz_q      <= FRZ_NONE;
         frz_val_q  <= '0;
         st_v_q     <= 1'b0;
         st_q       <= '0;
         pend_q     <= 1'b0;
         load_q     <= 1'b0;
         load_val_q <= '0;
         cfg_q      <= 1'b0;
      end else begin
         load_q <= do_load;
         cfg_q  <= cmd.cfg;
         if (do_load) load_val_q <= nxt_val;

         if (cmd.cfg) begin
            acc_q   <= cmd.acc;
            mode_q  <= cmd.mode;
            bcd_q   <= cmd.bcd;
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
         end else if (cnt_wr && acc_q == ACC_WORD) begin
            wr_hi_q <= ~wr_hi_q;
            if (!wr_hi_q) wlo_q <= wdata;
         end else if (cnt_rd && !st_v_q && frz_q == FRZ_NONE && acc_q == ACC_WORD) begin
            rd_hi_q <= ~rd_hi_q;
         end

         if (cmd.cnt_frz && frz_q == FRZ_NONE) begin
            frz_q     <= frz_of(acc_q);
            frz_val_q <= live;
         end else if (cnt_rd && !st_v_q) begin
            frz_q <= (frz_q == FRZ_WORD) ? FRZ_HI : FRZ_NONE;
         end

         if (cmd.st_frz && !st_v_q) begin
            st_v_q <= 1'b1;
            st_q   <= {out_lvl, pend_q, acc_q, mode_q, bcd_q};
         end else if (cnt_rd) begin
            st_v_q <= 1'b0;
         end

         if (do_load)   pend_q <= 1'b1;
         else if (xfer) pend_q <= 1'b0;
      end
   end

   assign load     = load_q;
   assign load_val = load_val_q;
   assign cfg      = cfg_q;
   assign mode     = mode_q;
   assign bcd      = bcd_q;

endmodule

// File: rtl/tmr_busif.sv
module tmr_busif
   import tmr_busif_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [1:0]         bus_addr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   output logic [NCH-1:0]     ch_load,
   output logic [NCH*16-1:0]  ch_load_val,
   output logic [NCH-1:0]     ch_cfg,
   output logic [NCH*3-1:0]   ch_mode,
   output logic [NCH-1:0]     ch_bcd,
   input  logic [NCH*16-1:0]  ch_live,
   input  logic [NCH-1:0]     ch_out,
   input  logic [NCH-1:0]     ch_xfer
);

   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("tmr_busif: NCH must be 1..3, the control port occupies address 3");
   end

   chan_cmd_t [NCH-1:0] cmd;
   logic [NCH-1:0]      cnt_wr;
   logic [NCH-1:0]      cnt_rd;
   logic [7:0]          rbyte [NCH];

   tmr_busif_decode #(.NCH(NCH)) u_dec (
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cmd       (cmd),
      .cnt_wr    (cnt_wr),
      .cnt_rd    (cnt_rd)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      tmr_busif_chan u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmd      (cmd[c]),
         .cnt_wr   (cnt_wr[c]),
         .cnt_rd   (cnt_rd[c]),
         .wdata    (bus_wdata),
         .live     (ch_live[c*CNT_W +: CNT_W]),
         .out_lvl  (ch_out[c]),
         .xfer     (ch_xfer[c]),
         .rbyte    (rbyte[c]),
         .load     (ch_load[c]),
         .load_val (ch_load_val[c*CNT_W +: CNT_W]),
         .cfg      (ch_cfg[c]),
         .mode     (ch_mode[c*3 +: 3]),
         .bcd      (ch_bcd[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NCH; c++) begin
         if (bus_addr == 2'(c)) bus_rdata = rbyte[c];
      end
   end

endmodule

// File: rtl/tmr_busif_chk.sv
module tmr_busif_chk #(
   parameter int NCH = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [1:0]       bus_addr,
   input logic [7:0]       bus_rdata,
   input logic [NCH-1:0]   ch_load,
   input logic [NCH-1:0]   ch_cfg,
   input logic [NCH*3-1:0] ch_mode
);

   a_r3_single_load: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_load));

   a_r3_load_needs_count_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_load) |-> $past(bus_wr && bus_addr != 2'd3));

   a_r3_idle_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> (ch_load == '0));

   a_r2_cfg_needs_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|ch_cfg) |-> $past(bus_wr && bus_addr == 2'd3));

   a_r2_mode_moves_with_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ch_mode) |-> (|ch_cfg));

   a_r13_ctrl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

endmodule

bind tmr_busif tmr_busif_chk #(.NCH(NCH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .ch_load   (ch_load),
   .ch_cfg    (ch_cfg),
   .ch_mode   (ch_mode)
);

// File: tb/tmr_busif_tb.sv
`timescale 1ns/1ps
module tmr_busif_tb;

   localparam int NCH = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [1:0]        bus_addr = 2'd0;
   logic [7:0]        bus_wdata = 8'h00;
   logic [7:0]        bus_rdata;
   logic [NCH-1:0]    ch_load;
   logic [NCH*16-1:0] ch_load_val;
   logic [NCH-1:0]    ch_cfg;
   logic [NCH*3-1:0]  ch_mode;
   logic [NCH-1:0]    ch_bcd;
   logic [NCH*16-1:0] ch_live;
   logic [NCH-1:0]    ch_out;
   logic [NCH-1:0]    ch_xfer;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   bit  run = 1'b0;
   bit  xfer_en = 1'b0;

   always #2.5 clk = ~clk;

   tmr_busif #(.NCH(NCH)) u_dut (.*);

   // simple counter model standing in for the channels
   logic [15:0] cnt [NCH];
   for (genvar c = 0; c < NCH; c++) begin : g_cm
      assign ch_live[c*16 +: 16] = cnt[c];
      assign ch_out[c] = (cnt[c] == 16'd0);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt[c]     <= '0;
            ch_xfer[c] <= 1'b0;
         end else begin
            ch_xfer[c] <= ch_load[c] && xfer_en;
            if (ch_load[c])  cnt[c] <= ch_load_val[c*16 +: 16];
            else if (run)    cnt[c] <= cnt[c] - 16'd1;
         end
      end
   end

   // behavioural reference model
   int m_acc[NCH], m_mode[NCH], m_bcd[NCH], m_wrhi[NCH], m_rdhi[NCH], m_wlo[NCH];
   int m_lat[NCH], m_latv[NCH], m_stv[NCH], m_st[NCH], m_pend[NCH];
   int m_ld[NCH], m_ldv[NCH], m_cfg[NCH];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_acc[c] = 1; m_mode[c] = 0; m_bcd[c] = 0; m_wrhi[c] = 0; m_rdhi[c] = 0;
            m_wlo[c] = 0; m_lat[c] = 0; m_latv[c] = 0; m_stv[c] = 0; m_st[c] = 0;
            m_pend[c] = 0; m_ld[c] = 0; m_ldv[c] = 0; m_cfg[c] = 0;
         end
      end else begin
         int w, a;
         w = bus_wdata;
         a = bus_addr;
         for (int c = 0; c < NCH; c++) begin m_ld[c] = 0; m_cfg[c] = 0; end
         if (bus_wr && a == 3) begin
            for (int c = 0; c < NCH; c++) begin
               bit frz, st;
               frz = 0; st = 0;
               if ((w >> 6) == 3) begin
                  if (w[c+1]) begin frz = !w[5]; st = !w[4]; end
               end else if ((w >> 6) == c) begin
                  if (((w >> 4) & 3) == 0) frz = 1;
                  else begin
                     m_acc[c] = (w >> 4) & 3; m_mode[c] = (w >> 1) & 7; m_bcd[c] = w & 1;
                     m_wrhi[c] = 0; m_rdhi[c] = 0; m_cfg[c] = 1;
                  end
               end
               if (frz && m_lat[c] == 0) begin m_lat[c] = m_acc[c]; m_latv[c] = cnt[c]; end
               if (st && m_stv[c] == 0) begin
                  m_stv[c] = 1;
                  m_st[c] = (int'(ch_out[c]) << 7) | (m_pend[c] << 6) | (m_acc[c] << 4)
                            | (m_mode[c] << 1) | m_bcd[c];
               end
            end
         end
         for (int c = 0; c < NCH; c++) if (ch_xfer[c]) m_pend[c] = 0;
         if (bus_wr && a < NCH) begin
            if (m_acc[a] == 1)      begin m_ld[a] = 1; m_ldv[a] = w; end
            else if (m_acc[a] == 2) begin m_ld[a] = 1; m_ldv[a] = w * 256; end
            else if (m_wrhi[a] == 0) begin m_wlo[a] = w; m_wrhi[a] = 1; end
            else begin m_ld[a] = 1; m_ldv[a] = w * 256 + m_wlo[a]; m_wrhi[a] = 0; end
            if (m_ld[a] == 1) m_pend[a] = 1;
         end
         if (bus_rd && a < NCH) begin
            if (m_stv[a] == 1)      m_stv[a] = 0;
            else if (m_lat[a] == 3) m_lat[a] = 2;
            else if (m_lat[a] != 0) m_lat[a] = 0;
            else if (m_acc[a] == 3) m_rdhi[a] = 1 - m_rdhi[a];
         end
      end
   end

   function automatic int exp_byte(int a);
      int v;
      if (a >= NCH) return 0;
      if (m_stv[a] == 1) return m_st[a];
      if (m_lat[a] == 1 || m_lat[a] == 3) return m_latv[a] & 255;
      if (m_lat[a] == 2) return (m_latv[a] >> 8) & 255;
      v = cnt[a];
      if (m_acc[a] == 2 || (m_acc[a] == 3 && m_rdhi[a] == 1)) return (v >> 8) & 255;
      return v & 255;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R10/R13 rdata vs model", bus_rdata, exp_byte(bus_addr));
         for (int c = 0; c < NCH; c++) begin
            chk("R3/R4 load pulse vs model", ch_load[c], m_ld[c]);
            if (m_ld[c] == 1) chk("R3/R4 load value vs model", ch_load_val[c*16 +: 16], m_ldv[c]);
            chk("R2 cfg pulse vs model", ch_cfg[c], m_cfg[c]);
            chk("R2 mode vs model", ch_mode[c*3 +: 3], m_mode[c]);
            chk("R2 bcd vs model", ch_bcd[c], m_bcd[c]);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rdchk(input logic [1:0] a, input int exp, input string tag);
      logic [7:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 no load after reset", ch_load, 0);
      chk("R1 mode after reset", ch_mode, 0);
      rdchk(2'd0, 8'h00, "R1 live low byte after reset");
      wr(2'd3, 8'hE2);
      rdchk(2'd0, 8'h90, "R1/R8 reset status byte");
      // R2 configure ch0 word, mode 2, bcd
      wr(2'd3, 8'h35);
      chk("R2 ch_mode ch0", ch_mode[2:0], 2);
      chk("R2 ch_bcd ch0", ch_bcd[0], 1);
      wr(2'd3, 8'hE2);
      rdchk(2'd0, 8'hB5, "R2/R8 status after config");
      // R4 word write, R12 pending flag held
      wr(2'd0, 8'h34);
      chk("R4 no load after first byte", ch_load, 0);
      wr(2'd0, 8'h12);
      idle(2);
      rdchk(2'd0, 8'h34, "R10 word live low");
      rdchk(2'd0, 8'h12, "R4/R10 word live high");
      wr(2'd3, 8'hE2);
      rdchk(2'd0, 8'h75, "R12 pending flag set");
      xfer_en = 1'b1;
      wr(2'd0, 8'h78); wr(2'd0, 8'h56);
      idle(3);
      wr(2'd3, 8'hE2);
      rdchk(2'd0, 8'h35, "R12 pending flag cleared by transfer");
      // R5 freeze
      wr(2'd3, 8'h00);
      wr(2'd0, 8'hCD); wr(2'd0, 8'hAB);
      idle(2);
      rdchk(2'd0, 8'h78, "R5 frozen low");
      rdchk(2'd0, 8'h56, "R5 frozen high");
      rdchk(2'd0, 8'hCD, "R5 released live low");
      rdchk(2'd0, 8'hAB, "R5 released live high");
      // R6 second freeze ignored
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h11); wr(2'd0, 8'h11);
      idle(2);
      wr(2'd3, 8'h00);
      rdchk(2'd0, 8'hCD, "R6 older frozen low kept");
      rdchk(2'd0, 8'hAB, "R6 older frozen high kept");
      // R11 sequencing restart
      rdchk(2'd0, 8'h11, "R10 live low");
      wr(2'd0, 8'h22);
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h44); wr(2'd0, 8'h33);
      idle(2);
      rdchk(2'd0, 8'h44, "R11 read order restarted");
      rdchk(2'd0, 8'h33, "R11 write order restarted");
      // R3 byte-only access on ch1
      wr(2'd3, 8'h50);
      wr(2'd1, 8'h9A);
      idle(2);
      rdchk(2'd1, 8'h9A, "R3 low-only load");
      wr(2'd3, 8'h60);
      wr(2'd1, 8'h5B);
      idle(2);
      rdchk(2'd1, 8'h5B, "R3 high-only load");
      wr(2'd3, 8'h50);
      rdchk(2'd1, 8'h00, "R3 high-only low byte zero");
      // R7 multi-channel freeze of ch0 and ch2
      wr(2'd3, 8'hB0);
      wr(2'd2, 8'hEF); wr(2'd2, 8'hBE);
      idle(2);
      wr(2'd3, 8'hDA);
      wr(2'd0, 8'h01); wr(2'd0, 8'h02);
      wr(2'd1, 8'h77);
      idle(2);
      rdchk(2'd0, 8'h44, "R7 ch0 frozen low");
      rdchk(2'd0, 8'h33, "R7 ch0 frozen high");
      rdchk(2'd2, 8'hEF, "R7 ch2 frozen low");
      rdchk(2'd2, 8'hBE, "R7 ch2 frozen high");
      rdchk(2'd1, 8'h77, "R7 ch1 unselected stays live");
      // R9 status before count
      idle(3);
      wr(2'd3, 8'hC2);
      rdchk(2'd0, 8'h30, "R9 status first");
      rdchk(2'd0, 8'h01, "R9 then frozen low");
      rdchk(2'd0, 8'h02, "R9 then frozen high");
      // R8 second status freeze ignored
      wr(2'd3, 8'hE2);
      wr(2'd0, 8'h00); wr(2'd0, 8'h00);
      idle(3);
      wr(2'd3, 8'hE2);
      rdchk(2'd0, 8'h30, "R8 older status kept");
      wr(2'd3, 8'hE2);
      rdchk(2'd0, 8'hB0, "R8 status shows output level");
      // R13
      rdchk(2'd3, 8'h00, "R13 control port reads zero");
      // random phase
      run = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         int op;
         logic [7:0] v;
         op = $urandom_range(0, 3);
         case (op)
            0: idle(1);
            1: wr(2'd3, 8'($urandom_range(0, 255)));
            2: wr(2'($urandom_range(0, 2)), 8'($urandom_range(0, 255)));
            default: rd(2'($urandom_range(0, 3)), v);
         endcase
      end
      idle(2);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule